// File: doc/BRIEF.md
# Packed 16-bit SIMD Shifter

This execution unit shifts every 16-bit lane of a packed word by one shared amount in a single clocked stage. It offers arithmetic right, logical right and logical left shifts. The amount comes either from the low bits of the second source operand or from a 4-bit immediate. A bidirectional form reads a signed amount and shifts left with saturation or right arithmetically. A two-bit mode field turns right shifts into rounding shifts and left shifts into saturating shifts.

The unit also checks the register indices that come with the operation. If any index lies outside the permitted window, the unit zeroes the result and raises an illegal-operand flag. A sticky flag records that any lane clamped. The flag holds until it is cleared.

Top module: `simd_shf`

## Requirements
- R1: Every 16-bit lane of `src1_i` (four lanes at the default width of 64) is shifted on its own by the same amount. Lane k occupies bits [16k+15:16k].
- R2: Opcode `op_i` is 00 for arithmetic right, 01 for logical right, 10 for logical left and 11 for bidirectional. For opcodes 00 to 10 the amount is `imm_i` when `imm_sel_i`=1 and `src2_i[3:0]` when `imm_sel_i`=0. Bit 4 of `src2_i` has no effect on those opcodes.
- R3: With `mode_i`=00, right shifts truncate and left shifts wrap, keeping the low 16 bits.
- R4: With `mode_i`=01, a right shift by n>0 adds bit n-1 of the original lane to the truncated result. A shift by 0 returns the lane unchanged.
- R5: With `mode_i`=01, a logical left shift that would lose significant bits (the result read as signed differs from lane·2^n) clamps the lane. A non-negative lane clamps to 0x7FFF and a negative lane clamps to 0x8000.
- R6: For opcode 11, `src2_i[4:0]` is a signed amount and `imm_sel_i` is ignored. A value of 0 to 15 gives a saturating left shift whatever the mode. A value of -1 to -15 gives an arithmetic right shift by the magnitude, rounded when `mode_i`=01. A value of -16 shifts right by 15.
- R7: `rd_idx_i` and `rs1_idx_i` must lie in 16..29. `rs2_idx_i` must also lie in 16..29, except for immediate forms of opcodes 00 to 10, where it has no effect. On a violation, `ill_o` is 1, `res_o` is 0 and the clamp has no effect on `sat_o`.
- R8: `sat_o` is sticky. It becomes 1 when any lane of a legal operation clamps and stays 1 until a cycle with `sat_clr_i`=1 and no new clamp.
- R9: The outputs are registered with one cycle of latency. After reset, `res_o`, `sat_o` and `ill_o` are 0.
- R10: Mode values 10 and 11 behave exactly like 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Shift operation code |
| imm_sel_i | input | 1 | 1 selects the immediate amount |
| mode_i | input | 2 | 01 selects rounding or saturation |
| src1_i | input | WIDTH | Packed lanes to shift |
| src2_i | input | 5 | Low bits of second source operand (amount) |
| imm_i | input | 4 | Immediate amount |
| rd_idx_i | input | 5 | Destination register index |
| rs1_idx_i | input | 5 | First source register index |
| rs2_idx_i | input | 5 | Second source register index |
| sat_clr_i | input | 1 | Clears the sticky saturation flag |
| res_o | output | WIDTH | Shifted packed result |
| sat_o | output | 1 | Sticky saturation flag |
| ill_o | output | 1 | Illegal register index flag |

## Verification
The shift path holds no state. A wrong amount decode, rounding bit or clamp condition therefore shows up in `res_o` one cycle after the operation is applied. It typically appears only in the lane whose value sits at a boundary, such as 0x7FFF, 0x8000 or 0xFFFF, or at amounts 0 and 15. The only state is the sticky flag. A fault there shows only on later operations, when the flag drops without a clear or rises on an illegal operation. The bench therefore follows clamping operations with non-clamping and illegal ones.

// File: rtl/simd_shf_pkg.sv
package simd_shf_pkg;
   localparam int unsigned LANE_W  = 16;
   localparam int unsigned SHAMT_W = $clog2(LANE_W);
   localparam int unsigned IDX_W   = 5;

   typedef enum logic [1:0] {
      SHF_SRA  = 2'b00,
      SHF_SRL  = 2'b01,
      SHF_SLL  = 2'b10,
      SHF_BIDI = 2'b11
   } shf_op_e;

   localparam logic [1:0] MODE_SPECIAL = 2'b01;

   typedef struct packed {
      logic [SHAMT_W-1:0] amt;
      logic               left;
      logic               arith;
      logic               rnd;
      logic               sat;
   } shf_ctl_t;
endpackage

// File: rtl/simd_shf_ctl.sv
module simd_shf_ctl
   import simd_shf_pkg::*;
(
   input  logic [1:0]          op_i,
   input  logic                imm_sel_i,
   input  logic [1:0]          mode_i,
   input  logic [SHAMT_W:0]    src2_i,
   input  logic [SHAMT_W-1:0]  imm_i,
   output shf_ctl_t            ctl_o
);
   logic               special;
   logic [SHAMT_W-1:0] uamt;
   logic [SHAMT_W:0]   mag;

   always_comb begin
      special = (mode_i == MODE_SPECIAL);
      uamt    = imm_sel_i ? imm_i : src2_i[SHAMT_W-1:0];
      mag     = (~src2_i) + 1'b1;
      ctl_o   = '0;
      unique case (shf_op_e'(op_i))
         SHF_SRA: begin
            ctl_o.amt   = uamt;
            ctl_o.arith = 1'b1;
            ctl_o.rnd   = special;
         end
         SHF_SRL: begin
            ctl_o.amt = uamt;
            ctl_o.rnd = special;
         end
         SHF_SLL: begin
            ctl_o.amt  = uamt;
            ctl_o.left = 1'b1;
            ctl_o.sat  = special;
         end
         default: begin
            if (!src2_i[SHAMT_W]) begin
               ctl_o.amt  = src2_i[SHAMT_W-1:0];
               ctl_o.left = 1'b1;
               ctl_o.sat  = 1'b1;
            end else begin
               ctl_o.amt   = mag[SHAMT_W] ? {SHAMT_W{1'b1}} : mag[SHAMT_W-1:0];
               ctl_o.arith = 1'b1;
               ctl_o.rnd   = special;
            end
         end
      endcase
   end
endmodule

// File: rtl/simd_shf_regchk.sv
module simd_shf_regchk
   import simd_shf_pkg::*;
#(
   parameter int unsigned REG_LO = 16,
   parameter int unsigned REG_HI = 29
) (
   input  logic [IDX_W-1:0] rd_i,
   input  logic [IDX_W-1:0] rs1_i,
   input  logic [IDX_W-1:0] rs2_i,
   input  logic             use_rs2_i,
   output logic             bad_o
);
   localparam logic [IDX_W-1:0] LO = IDX_W'(REG_LO);
   localparam logic [IDX_W-1:0] HI = IDX_W'(REG_HI);

   function automatic logic out_of_win(input logic [IDX_W-1:0] idx);
      return (idx < LO) || (idx > HI);
   endfunction

   assign bad_o = out_of_win(rd_i) || out_of_win(rs1_i) ||
                  (use_rs2_i && out_of_win(rs2_i));
endmodule

// File: rtl/simd_shf_lane.sv
module simd_shf_lane
   import simd_shf_pkg::*;
(
   input  logic [LANE_W-1:0] x_i,
   input  shf_ctl_t          ctl_i,
   output logic [LANE_W-1:0] y_o,
   output logic              clamp_o
);
   logic [2*LANE_W-1:0]        wide;
   logic [LANE_W-1:0]          trunc;
   logic                       rbit;
   logic [LANE_W-1:0]          lsh;
   logic signed [LANE_W-1:0]   back;

   always_comb begin
      wide    = {{LANE_W{ctl_i.arith & x_i[LANE_W-1]}}, x_i} >> ctl_i.amt;
      trunc   = wide[LANE_W-1:0];
      rbit    = (ctl_i.rnd && ctl_i.amt != '0) ? x_i[ctl_i.amt - 1'b1] : 1'b0;
      lsh     = x_i << ctl_i.amt;
      back    = $signed(lsh) >>> ctl_i.amt;
      clamp_o = ctl_i.left && ctl_i.sat && (back != $signed(x_i));
      if (!ctl_i.left)
         y_o = trunc + LANE_W'(rbit);
      else if (clamp_o)
         y_o = {x_i[LANE_W-1], {(LANE_W-1){~x_i[LANE_W-1]}}};
      else
         y_o = lsh;
   end

   // R4
   always_comb begin
      if (!ctl_i.left && ctl_i.arith)
         arith_sign_chk: assert (y_o[LANE_W-1] == x_i[LANE_W-1] || y_o == '0);
   end
endmodule

// File: rtl/simd_shf.sv
module simd_shf
   import simd_shf_pkg::*;
#(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned REG_LO = 16,
   parameter int unsigned REG_HI = 29
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [1:0]           op_i,
   input  logic                 imm_sel_i,
   input  logic [1:0]           mode_i,
   input  logic [WIDTH-1:0]     src1_i,
   input  logic [SHAMT_W:0]     src2_i,
   input  logic [SHAMT_W-1:0]   imm_i,
   input  logic [IDX_W-1:0]     rd_idx_i,
   input  logic [IDX_W-1:0]     rs1_idx_i,
   input  logic [IDX_W-1:0]     rs2_idx_i,
   input  logic                 sat_clr_i,
   output logic [WIDTH-1:0]     res_o,
   output logic                 sat_o,
   output logic                 ill_o
);
   localparam int unsigned LANES = WIDTH / LANE_W;

   if (WIDTH % LANE_W != 0 || WIDTH == 0) begin : g_bad_width
      $error("simd_shf: WIDTH must be a nonzero multiple of 16");
   end
   if (REG_LO > REG_HI || REG_HI >= (1 << IDX_W)) begin : g_bad_win
      $error("simd_shf: register window out of range");
   end

   shf_ctl_t          ctl;
   logic              bad;
   logic              use_rs2;
   logic [WIDTH-1:0]  shifted;
   logic [LANES-1:0]  clamp;

   simd_shf_ctl u_ctl (
      .op_i      (op_i),
      .imm_sel_i (imm_sel_i),
      .mode_i    (mode_i),
      .src2_i    (src2_i),
      .imm_i     (imm_i),
      .ctl_o     (ctl)
   );

   assign use_rs2 = (op_i == SHF_BIDI) || !imm_sel_i;

   simd_shf_regchk #(.REG_LO(REG_LO), .REG_HI(REG_HI)) u_regchk (
      .rd_i      (rd_idx_i),
      .rs1_i     (rs1_idx_i),
      .rs2_i     (rs2_idx_i),
      .use_rs2_i (use_rs2),
      .bad_o     (bad)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      simd_shf_lane u_lane (
         .x_i     (src1_i[g*LANE_W +: LANE_W]),
         .ctl_i   (ctl),
         .y_o     (shifted[g*LANE_W +: LANE_W]),
         .clamp_o (clamp[g])
      );
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         res_o <= '0;
         sat_o <= 1'b0;
         ill_o <= 1'b0;
      end else begin
         res_o <= bad ? '0 : shifted;
         ill_o <= bad;
         sat_o <= (sat_clr_i ? 1'b0 : sat_o) | (!bad && (|clamp));
      end
   end

   // R7
   ill_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad |=> (ill_o && res_o == '0));
   // R7
   ill_keep_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bad && !sat_clr_i) |=> $stable(sat_o));
   // R8
   sat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sat_o && !sat_clr_i) |=> sat_o);
   // R8
   sat_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sat_o) |-> !ill_o);
endmodule

// File: tb/simd_shf_tb.sv
module simd_shf_tb;
   localparam int W = 64;
   localparam int L = W / 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    op = '0;
   logic          imm_sel = 1'b0;
   logic [1:0]    mode = '0;
   logic [W-1:0]  a = '0;
   logic [4:0]    b = '0;
   logic [3:0]    imm = '0;
   logic [4:0]    rd = 5'd16, rs1 = 5'd17, rs2 = 5'd18;
   logic          clr = 1'b0;
   logic [W-1:0]  res;
   logic          sat, ill;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   simd_shf #(.WIDTH(W)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .op_i(op), .imm_sel_i(imm_sel), .mode_i(mode),
      .src1_i(a), .src2_i(b), .imm_i(imm), .rd_idx_i(rd), .rs1_idx_i(rs1),
      .rs2_idx_i(rs2), .sat_clr_i(clr), .res_o(res), .sat_o(sat), .ill_o(ill));

   // op(2) imm_sel(1) mode(2) amt(5) lane(16) expected(16) sat(1)
   localparam int NV = 10;
   localparam logic [42:0] VEC [NV] = '{
      {2'b00, 1'b0, 2'b00, 5'd1,  16'h8000, 16'hC000, 1'b0},
      {2'b00, 1'b1, 2'b01, 5'd1,  16'h0003, 16'h0002, 1'b0},
      {2'b01, 1'b0, 2'b00, 5'd15, 16'hFFFF, 16'h0001, 1'b0},
      {2'b01, 1'b1, 2'b01, 5'd15, 16'hFFFF, 16'h0002, 1'b0},
      {2'b10, 1'b0, 2'b00, 5'd1,  16'h7FFF, 16'hFFFE, 1'b0},
      {2'b10, 1'b0, 2'b01, 5'd1,  16'h7FFF, 16'h7FFF, 1'b1},
      {2'b10, 1'b1, 2'b01, 5'd15, 16'hFFFF, 16'h8000, 1'b0},
      {2'b11, 1'b0, 2'b01, 5'h1F, 16'h0003, 16'h0002, 1'b0},
      {2'b11, 1'b0, 2'b00, 5'h10, 16'h8000, 16'hFFFF, 1'b0},
      {2'b11, 1'b0, 2'b00, 5'd2,  16'h4000, 16'h7FFF, 1'b1}
   };

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Lane model: returns {clamp, value}
   function automatic logic [16:0] model(input logic [1:0] o, input logic is, input logic [1:0] m,
                                          input logic [15:0] x, input logic [4:0] bb, input logic [3:0] ii);
      int n, v, q, p;
      bit left, ar, rn, st, cl;
      bit sp = (m == 2'b01);
      left = 0; ar = 0; rn = 0; st = 0; cl = 0;
      n = is ? int'(ii) : int'(bb[3:0]);
      case (o)
         2'b00: begin ar = 1; rn = sp; end
         2'b01: rn = sp;
         2'b10: begin left = 1; st = sp; end
         default: begin
            if (!bb[4]) begin left = 1; st = 1; n = int'(bb[3:0]); end
            else begin
               n = 32 - int'(bb);
               if (n == 16) n = 15;
               ar = 1; rn = sp;
            end
         end
      endcase
      if (left) begin
         p = int'($signed(x)) * (1 << n);
         if (st && (p > 32767 || p < -32768)) begin
            cl = 1;
            q = x[15] ? 32'h8000 : 32'h7FFF;
         end else q = p;
      end else begin
         v = ar ? int'($signed(x)) : int'(x);
         q = v >>> n;
         if (rn && n > 0) q = q + ((v >>> (n - 1)) & 1);
      end
      return {cl, q[15:0]};
   endfunction

   task automatic apply(input logic [1:0] o, input logic is, input logic [1:0] m,
                        input logic [W-1:0] aa, input logic [4:0] bb, input logic c);
      @(negedge clk);
      op = o; imm_sel = is; mode = m; a = aa; b = bb; imm = bb[3:0]; clr = c;
      @(posedge clk);
      #1;
   endtask

   task automatic run_model(input logic [1:0] o, input logic is, input logic [1:0] m,
                            input logic [W-1:0] aa, input logic [4:0] bb, input string req);
      logic [W-1:0] e;
      logic es;
      logic [16:0] r;
      es = 1'b0;
      for (int k = 0; k < L; k++) begin
         r = model(o, is, m, aa[k*16 +: 16], bb, bb[3:0]);
         e[k*16 +: 16] = r[15:0];
         es |= r[16];
      end
      apply(o, is, m, aa, bb, 1'b1);
      check(req, res, e);
      check({req, " sat"}, W'(sat), W'(es));
   endtask

   initial begin
      logic [W-1:0] pats [2];
      logic [4:0] amts [7];
      pats[0] = 64'h7FFF_8000_FFFF_0001;
      pats[1] = 64'h0003_C001_4000_0000;
      amts = '{5'd0, 5'd1, 5'd7, 5'd15, 5'h10, 5'h1F, 5'h18};

      repeat (3) @(posedge clk);
      #1;
      // R9 reset state
      check("R9 reset res", res, '0);
      check("R9 reset flags", W'({sat, ill}), '0);
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk (R1 all lanes equal)
      for (int i = 0; i < NV; i++) begin
         logic [42:0] t;
         t = VEC[i];
         apply(t[42:41], t[40], t[39:38], {L{t[32:17]}}, t[37:33], 1'b1);
         check("R3/R4/R5/R6 table", res, {L{t[16:1]}});
         check("R5/R6 table sat", W'(sat), W'(t[0]));
      end

      // Model sweep: R1 R2 R3 R4 R5 R6 R10
      for (int o = 0; o < 4; o++)
         for (int is = 0; is < 2; is++)
            for (int m = 0; m < 4; m++)
               for (int ai = 0; ai < 7; ai++)
                  for (int pi = 0; pi < 2; pi++)
                     run_model(2'(o), 1'(is), 2'(m), pats[pi], amts[ai], "R1 R2 R6 R10 sweep");

      // R2: immediate form ignores src2
      @(negedge clk);
      op = 2'b01; imm_sel = 1'b1; mode = 2'b00; a = {L{16'hF000}}; b = 5'd0; imm = 4'd4; clr = 1'b1;
      @(posedge clk); #1;
      check("R2 imm amount", res, {L{16'h0F00}});

      // R8 sticky
      apply(2'b10, 1'b0, 2'b01, {L{16'h4000}}, 5'd1, 1'b1);
      check("R8 set", W'(sat), W'(1));
      apply(2'b10, 1'b0, 2'b00, {L{16'h0001}}, 5'd1, 1'b0);
      check("R8 hold", W'(sat), W'(1));
      check("R8 hold res", res, {L{16'h0002}});
      apply(2'b10, 1'b0, 2'b00, {L{16'h0001}}, 5'd1, 1'b1);
      check("R8 clear", W'(sat), W'(0));

      // R7 illegal indices
      rd = 5'd15;
      apply(2'b10, 1'b0, 2'b01, {L{16'h4000}}, 5'd1, 1'b0);
      check("R7 rd low res", res, '0);
      check("R7 rd low flags", W'({ill, sat}), W'(2'b10));
      rd = 5'd16; rs1 = 5'd30;
      apply(2'b00, 1'b0, 2'b00, {L{16'h8000}}, 5'd1, 1'b0);
      check("R7 rs1 high", W'({ill, sat}), W'(2'b10));
      rs1 = 5'd29; rs2 = 5'd31;
      apply(2'b00, 1'b0, 2'b00, {L{16'h8000}}, 5'd1, 1'b0);
      check("R7 rs2 reg form", W'(ill), W'(1));
      apply(2'b00, 1'b1, 2'b00, {L{16'h8000}}, 5'd1, 1'b0);
      check("R7 rs2 imm form legal", W'(ill), W'(0));
      check("R7 imm form res", res, {L{16'hC000}});
      apply(2'b11, 1'b1, 2'b00, {L{16'h8000}}, 5'd1, 1'b0);
      check("R7 bidi uses rs2", W'(ill), W'(1));
      rs2 = 5'd16; rd = 5'd29;
      // set sat then illegal must keep it
      apply(2'b10, 1'b0, 2'b01, {L{16'h4000}}, 5'd1, 1'b1);
      rd = 5'd0;
      apply(2'b01, 1'b0, 2'b00, {L{16'h0001}}, 5'd0, 1'b0);
      check("R7 illegal keeps sat", W'({ill, sat}), W'(2'b11));
      rd = 5'd16;

      // R9 one-cycle latency
      @(negedge clk);
      op = 2'b01; imm_sel = 1'b0; mode = 2'b00; a = {L{16'h00F0}}; b = 5'd4; clr = 1'b1;
      #1;
      check("R9 no early change", res, '0);
      @(posedge clk); #1;
      check("R9 latency", res, {L{16'h000F}});

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule